// File: doc/BRIEF.md
# Power-Good Window Monitor with Voltage-Step Blanking

This block decides whether a regulator output is inside its allowed band. It takes a digitized feedback value and the current target in the same units. It compares the two with four percentage thresholds. Undervoltage and overvoltage each have a trip level and a separate, tighter return level, so a reading that sits near a trip level does not make the status chatter. The comparisons scale both operands by integer constants, so no divider is needed.

When the controller accepts a new output-voltage code, it pulses a strobe. The strobe opens a blanking window of a fixed number of cycles. Inside that window the power-good bit keeps the value it had before the change, and the fault state is not updated. For the same window the block raises a request for forced continuous conduction, so the output can discharge on a downward step. A strobe that arrives while a window is open starts the full length again. The power-good bit is meant to be read back over the serial control bus.

Top module: `pgw_monitor`

## Requirements
- R1: While reset is high, and in the first cycle after it, pgood and fccm_req are 0. The undervoltage fault starts out set and the overvoltage fault starts out clear.
- R2: When no window is open, a sample with fb_code*100 < tgt_code*80 sets the undervoltage fault, and pgood is 0 after the next rising clock edge. Exactly 80 % does not trip.
- R3: A set undervoltage fault clears only on a sample with fb_code*100 > tgt_code*85. Samples from 80 % up to and including 85 % keep pgood at 0.
- R4: When no window is open, a sample with fb_code*100 > tgt_code*125 sets the overvoltage fault, and pgood is 0 after the next edge. Exactly 125 % does not trip.
- R5: A set overvoltage fault clears only on a sample with fb_code*100 < tgt_code*120. Samples from 120 % up to and including 125 % keep pgood at 0.
- R6: A code_chg pulse sampled at one edge makes fccm_req high from that edge for exactly BLANK_CYC cycles.
- R7: At the strobe edge and for every cycle fccm_req is high, pgood holds and both fault states hold. Readings taken inside the window are ignored, and only the first sample after the window counts.
- R8: A code_chg pulse sampled while fccm_req is high reloads the window to a full BLANK_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_code | input | FB_W | Digitized feedback value |
| tgt_code | input | FB_W | Target value in the same units as fb_code |
| code_chg | input | 1 | One-cycle strobe: a new voltage code was accepted |
| pgood | output | 1 | Registered power-good status |
| fccm_req | output | 1 | Registered forced-continuous-conduction request |

## Verification
The assertions assume that fb_code and tgt_code are held steady for at least one clock around each edge. They also assume that code_chg is a clean synchronous pulse and that reset lasts at least one edge. The bench changes inputs only on falling edges and keeps a target of 500 for most runs. Exact-boundary values (400, 425, 600 and 625) land on integer products, so the equal case of every threshold is tested without rounding. A second target checks that the thresholds scale with the target. Strobes are spaced both inside and outside an open window.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // Index of each threshold comparison in the hit vector.
  localparam int unsigned HIT_UV_SET = 0;
  localparam int unsigned HIT_UV_CLR = 1;
  localparam int unsigned HIT_OV_SET = 2;
  localparam int unsigned HIT_OV_CLR = 3;
  localparam int unsigned N_HIT      = 4;

  // One fault side: undervoltage or overvoltage.
  typedef enum logic [0:0] {
    SIDE_UV = 1'b0,
    SIDE_OV = 1'b1
  } pgw_side_e;

  localparam int unsigned N_SIDE = 2;
endpackage

// File: rtl/pgw_cmp.sv
module pgw_cmp
  import pgw_pkg::*;
#(
  parameter int unsigned FB_W      = 10,
  parameter int unsigned SCALE     = 100,
  parameter int unsigned UV_SET    = 80,
  parameter int unsigned UV_CLR    = 85,
  parameter int unsigned OV_SET    = 125,
  parameter int unsigned OV_CLR    = 120
) (
  input  logic [FB_W-1:0]  fb_code,
  input  logic [FB_W-1:0]  tgt_code,
  output logic [N_HIT-1:0] hit
);
  localparam int unsigned PW = FB_W + 8;
  localparam int unsigned PCT_TAB [N_HIT] = '{UV_SET, UV_CLR, OV_SET, OV_CLR};
  // 1 = fires when feedback is below the scaled level.
  localparam logic [N_HIT-1:0] BELOW = 4'b1001;

  logic [PW-1:0] fb_scaled;
  assign fb_scaled = PW'(fb_code) * PW'(SCALE);

  for (genvar i = 0; i < N_HIT; i++) begin : g_thr
    logic [PW-1:0] lvl;
    assign lvl = PW'(tgt_code) * PW'(PCT_TAB[i]);
    if (BELOW[i]) begin : g_lo
      assign hit[i] = fb_scaled < lvl;
    end else begin : g_hi
      assign hit[i] = fb_scaled > lvl;
    end
  end
endmodule

// File: rtl/pgw_hyst.sv
module pgw_hyst #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic set_c,
  input  logic clr_c,
  output logic flag_nxt,
  output logic flag_q
);
  always_comb begin
    flag_nxt = flag_q;
    if (!freeze) begin
      if (set_c)      flag_nxt = 1'b1;
      else if (clr_c) flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= flag_nxt;
  end
endmodule

// File: rtl/pgw_blank.sv
module pgw_blank #(
  parameter int unsigned BLANK_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic active_q,
  output logic mask
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      active_q <= 1'b0;
    end else begin
      if (strobe)           cnt <= CW'(BLANK_CYC);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
      active_q <= strobe | (cnt > CW'(1));
    end
  end

  assign mask = strobe | active_q;
endmodule

// File: rtl/pgw_monitor.sv
module pgw_monitor
  import pgw_pkg::*;
#(
  parameter int unsigned FB_W      = 10,
  parameter int unsigned BLANK_CYC = 12500,
  parameter int unsigned SCALE     = 100,
  parameter int unsigned UV_SET    = 80,
  parameter int unsigned UV_CLR    = 85,
  parameter int unsigned OV_SET    = 125,
  parameter int unsigned OV_CLR    = 120
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FB_W-1:0] fb_code,
  input  logic [FB_W-1:0] tgt_code,
  input  logic            code_chg,
  output logic            pgood,
  output logic            fccm_req
);
  logic [N_HIT-1:0]  hit;
  logic [N_SIDE-1:0] flt_nxt;
  logic [N_SIDE-1:0] flt_q;
  logic              mask;
  logic              pgood_q;

  pgw_cmp #(
    .FB_W(FB_W), .SCALE(SCALE),
    .UV_SET(UV_SET), .UV_CLR(UV_CLR), .OV_SET(OV_SET), .OV_CLR(OV_CLR)
  ) u_cmp (
    .fb_code (fb_code),
    .tgt_code(tgt_code),
    .hit     (hit)
  );

  pgw_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .strobe  (code_chg),
    .active_q(fccm_req),
    .mask    (mask)
  );

  // Side 0: undervoltage, starts faulted. Side 1: overvoltage, starts clear.
  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    localparam logic RV = (s == int'(SIDE_UV)) ? 1'b1 : 1'b0;
    pgw_hyst #(.RST_VAL(RV)) u_hyst (
      .clk     (clk),
      .rst     (rst),
      .freeze  (mask),
      .set_c   (hit[2*s]),
      .clr_c   (hit[2*s+1]),
      .flag_nxt(flt_nxt[s]),
      .flag_q  (flt_q[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       pgood_q <= 1'b0;
    else if (!mask) pgood_q <= ~(|flt_nxt);
  end

  assign pgood = pgood_q;
endmodule

// File: rtl/pgw_monitor_chk.sv
module pgw_monitor_chk #(
  parameter int unsigned FB_W      = 10,
  parameter int unsigned BLANK_CYC = 12500,
  parameter int unsigned SCALE     = 100,
  parameter int unsigned UV_SET    = 80,
  parameter int unsigned UV_CLR    = 85,
  parameter int unsigned OV_SET    = 125,
  parameter int unsigned OV_CLR    = 120
) (
  input logic            clk,
  input logic            rst,
  input logic [FB_W-1:0] fb_code,
  input logic [FB_W-1:0] tgt_code,
  input logic            code_chg,
  input logic            pgood,
  input logic            fccm_req
);
  localparam int unsigned PW = FB_W + 8;
  localparam int unsigned SW = $clog2(BLANK_CYC + 1) + 1;

  logic [PW-1:0] fbs, t_uvs, t_uvc, t_ovs, t_ovc;
  assign fbs   = PW'(fb_code) * PW'(SCALE);
  assign t_uvs = PW'(tgt_code) * PW'(UV_SET);
  assign t_uvc = PW'(tgt_code) * PW'(UV_CLR);
  assign t_ovs = PW'(tgt_code) * PW'(OV_SET);
  assign t_ovc = PW'(tgt_code) * PW'(OV_CLR);

  logic          open_win;
  assign open_win = code_chg | fccm_req;

  // Independent count of cycles since the last strobe.
  logic [SW-1:0] since;
  logic          seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (code_chg) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (since < SW'(BLANK_CYC)) begin
      since <= since + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!pgood && !fccm_req));

  a_r2_uv_trip: assert property (@(posedge clk) disable iff (rst)
    (!open_win && fbs < t_uvs) |=> !pgood);

  a_r4_ov_trip: assert property (@(posedge clk) disable iff (rst)
    (!open_win && fbs > t_ovs) |=> !pgood);

  // R3 and R5: inside both return levels the status comes back.
  a_r3_in_band: assert property (@(posedge clk) disable iff (rst)
    (!open_win && fbs > t_uvc && fbs < t_ovc) |=> pgood);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    open_win |=> $stable(pgood));

  a_r6_window_len: assert property (@(posedge clk) disable iff (rst)
    fccm_req == (seen && since < SW'(BLANK_CYC)));

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    code_chg |=> fccm_req);
endmodule

bind pgw_monitor pgw_monitor_chk #(
  .FB_W(FB_W), .BLANK_CYC(BLANK_CYC), .SCALE(SCALE),
  .UV_SET(UV_SET), .UV_CLR(UV_CLR), .OV_SET(OV_SET), .OV_CLR(OV_CLR)
) u_chk (
  .clk(clk), .rst(rst), .fb_code(fb_code), .tgt_code(tgt_code),
  .code_chg(code_chg), .pgood(pgood), .fccm_req(fccm_req)
);

// File: tb/test_pgw_monitor.sv
`timescale 1ns/1ps
module test_pgw_monitor;
  localparam int unsigned FB_W  = 10;
  localparam int unsigned BLANK = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [FB_W-1:0] fb_code = '0;
  logic [FB_W-1:0] tgt_code = '0;
  logic            code_chg = 1'b0;
  logic            pgood;
  logic            fccm_req;

  always #4 clk = ~clk;

  pgw_monitor #(.FB_W(FB_W), .BLANK_CYC(BLANK)) i_pgw_monitor (
    .clk(clk), .rst(rst), .fb_code(fb_code), .tgt_code(tgt_code),
    .code_chg(code_chg), .pgood(pgood), .fccm_req(fccm_req)
  );

  typedef struct {
    bit    pg;
    bit    fc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // Reference state from the requirements.
  bit m_uv = 1'b1, m_ov = 1'b0, m_pg = 1'b0;
  int m_cnt = 0;

  task automatic check(input bit pg, input bit fc, input bit epg, input bit efc, input string tag);
    n_cmp++;
    if (pg !== epg || fc !== efc) begin
      n_bad++;
      $display("FAIL %s: pgood=%0b fccm_req=%0b expected pgood=%0b fccm_req=%0b",
               tag, pg, fc, epg, efc);
    end
  endtask

  // Driver: apply one sample, predict the outputs after the next edge.
  task automatic step(input int fb, input int tg, input bit chg, input string tag);
    bit masked;
    exp_t e;
    @(negedge clk);
    fb_code  = FB_W'(fb);
    tgt_code = FB_W'(tg);
    code_chg = chg;
    masked = chg || (m_cnt != 0);
    if (!masked) begin
      if (fb * 100 < tg * 80)       m_uv = 1'b1;
      else if (fb * 100 > tg * 85)  m_uv = 1'b0;
      if (fb * 100 > tg * 125)      m_ov = 1'b1;
      else if (fb * 100 < tg * 120) m_ov = 1'b0;
      m_pg = !(m_uv || m_ov);
    end
    if (chg)             m_cnt = BLANK;
    else if (m_cnt != 0) m_cnt = m_cnt - 1;
    e.pg = m_pg; e.fc = (m_cnt != 0); e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(pgood, fccm_req, e.pg, e.fc, e.tag);
    end
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: pgood=%0b fccm_req=%0b expected pgood=x fccm_req=x", pgood, fccm_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pgood, fccm_req, 1'b0, 1'b0, "R1 in reset");
    rst = 1'b0;
    step(0, 500, 0, "R1 after reset");
    step(420, 500, 0, "R1 starts in low fault, 84pct");
    step(500, 500, 0, "R3 recovery from reset fault");
    // Undervoltage trip, boundaries.
    step(401, 500, 0, "R2 80.2pct keeps good");
    step(400, 500, 0, "R2 exactly 80pct keeps good");
    step(399, 500, 0, "R2 below 80pct trips");
    step(420, 500, 0, "R3 84pct stays low");
    step(425, 500, 0, "R3 exactly 85pct stays low");
    step(426, 500, 0, "R3 above 85pct recovers");
    // Overvoltage trip, boundaries.
    step(625, 500, 0, "R4 exactly 125pct keeps good");
    step(626, 500, 0, "R4 above 125pct trips");
    step(601, 500, 0, "R5 120.2pct stays low");
    step(600, 500, 0, "R5 exactly 120pct stays low");
    step(599, 500, 0, "R5 below 120pct recovers");
    step(500, 500, 0, "R2 nominal");
    // Window with fault readings that must be ignored.
    step(300, 500, 1, "R6 strobe opens window");
    for (int i = 0; i < 10; i++) step(300, 500, 0, "R7 low reading ignored");
    step(300, 500, 1, "R8 strobe restarts window");
    for (int i = 0; i < 15; i++) step(300, 500, 0, "R6 window still open");
    for (int i = 0; i < 8; i++) step(410, 500, 0, "R7 no fault latched in window");
    step(300, 500, 0, "R2 trips after window");
    // Window holding a low status while readings are good.
    step(500, 500, 1, "R6 strobe while faulted");
    for (int i = 0; i < 25; i++) step(500, 500, 0, "R7 low status held then released");
    // Overvoltage reading inside a window.
    step(700, 500, 1, "R6 strobe");
    for (int i = 0; i < 22; i++) step(500, 500, 0, "R7 high reading ignored");
    // Another target scales the thresholds.
    step(150, 200, 0, "R2 75pct of 200 trips");
    step(170, 200, 0, "R3 85pct of 200 stays low");
    step(180, 200, 0, "R3 90pct of 200 recovers");
    step(251, 200, 0, "R4 125.5pct of 200 trips");
    step(230, 200, 0, "R5 115pct of 200 recovers");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule